// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, for a conditional branch, whether it will be taken. Two component predictors run in parallel. The first forms an index from the outcomes of the most recent branches anywhere in the program, so it can learn correlations between branches. The second keeps a separate outcome history for each branch (selected by instruction address bits) and indexes with that, so it can learn a branch's own repeating pattern. A chooser table, also selected by address, learns for each branch which component to trust and forms the final answer.

The fetch stage presents a lookup address and reads the prediction combinationally in the same cycle. When a branch resolves, the back end presents its address and real direction with a valid strobe. The histories, both counter tables and the chooser are then trained at the next clock edge. A lookup and an update may arrive in the same cycle. History repair after a wrong guess is left to the surrounding logic.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every prediction counter is 1 (weakly not taken), the chooser counters are 1 (weakly favouring the per-branch predictor), and all histories are zero, so every lookup returns pred_taken_o=0 and use_global_o=0.
- R2: Each counter is 2 bits, values 0..3, saturating at both ends. It predicts taken when its upper bit is set. A taken update adds one and a not-taken update subtracts one, so a strongly biased counter changes its guess only after two consecutive opposite outcomes.
- R3: A 4-bit global history holds the latest resolved outcomes, newest in bit 0 (taken=1). It indexes a 16-entry global counter table. On every valid update the counter it addresses moves toward the outcome, and the outcome is then shifted in.
- R4: A 16-entry table of 4-bit per-branch histories is selected by address bits [5:2]. The selected history indexes a 16-entry local counter table. On a valid update that counter moves toward the outcome, and the outcome is shifted into bit 0 of that branch's history.
- R5: A 16-entry chooser table of 2-bit counters is selected by address bits [5:2]. It changes only when the two components disagree for the resolving branch: it adds one when the global component was right and subtracts one when the local component was right.
- R6: use_global_o is the upper bit of the chooser counter for the lookup address. pred_taken_o is the upper bit of the global counter when use_global_o=1, and of the local counter otherwise.
- R7: A lookup in the same cycle as an update returns the prediction from the state before that update. The update becomes visible from the next cycle.
- R8: With upd_valid_i low, no history, counter or chooser state changes, whatever upd_pc_i and upd_taken_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | 32 | Address of the branch being predicted |
| pred_taken_o | output | 1 | Final direction guess, 1 = taken |
| use_global_o | output | 1 | 1 when the global component supplied the guess |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Real direction of the resolved branch |

## Verification
The assertions check several things on every clock. Each counter steps by exactly one toward the update and holds at 0 or 3. A written history shifts in the resolved direction at bit 0. No table or history moves while the update strobe is low. None of that shows whether the tables learn the right things or whether the chooser picks the right component, so the bench scenarios cover those. They replay branch streams whose expected guesses follow from the counter and history rules. The streams include a counter flipping only after a second opposite outcome, a lookup that coincides with an update, and a mixed stream of several branches where the two components disagree and the chooser shifts its trust.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == CTR_ST)  ? CTR_ST  : c + 2'd1;
    else    r = (c == CTR_SNT) ? CTR_SNT : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
  import tbp_pkg::*;
#(
  parameter int   IDX_W   = 4,
  parameter ctr_t RST_VAL = CTR_WNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic [IDX_W-1:0] upd_idx_i,
  output ctr_t             upd_ctr_o,
  input  logic             wr_en_i,
  input  logic             wr_up_i
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][1:0] ctr_q, ctr_d;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign ctr_d[e] = (wr_en_i && upd_idx_i == IDX_W'(e)) ? ctr_step(ctr_q[e], wr_up_i)
                                                          : ctr_q[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctr_q <= {DEPTH{RST_VAL}};
    else         ctr_q <= ctr_d;
  end

  assign rd_ctr_o  = ctr_q[rd_idx_i];
  assign upd_ctr_o = ctr_q[upd_idx_i];

  // R2
  ctr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_up_i && upd_ctr_o != CTR_ST |=>
      ctr_q[$past(upd_idx_i)] == $past(upd_ctr_o) + 2'd1);

  // R2
  ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_up_i && upd_ctr_o != CTR_SNT |=>
      ctr_q[$past(upd_idx_i)] == $past(upd_ctr_o) - 2'd1);

  // R2
  ctr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ((wr_up_i && upd_ctr_o == CTR_ST) || (!wr_up_i && upd_ctr_o == CTR_SNT)) |=>
      ctr_q[$past(upd_idx_i)] == $past(upd_ctr_o));

  // R8
  ctr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctr_q));

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  upd_idx_i,
  output logic [HIST_W-1:0] upd_hist_o,
  input  logic              wr_en_i,
  input  logic              wr_bit_i
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][HIST_W-1:0] hist_q, hist_d;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign hist_d[e] = (wr_en_i && upd_idx_i == IDX_W'(e))
                     ? {hist_q[e][HIST_W-2:0], wr_bit_i}
                     : hist_q[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  assign rd_hist_o  = hist_q[rd_idx_i];
  assign upd_hist_o = hist_q[upd_idx_i];

  // R4
  lh_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(upd_idx_i)] ==
                {$past(upd_hist_o[HIST_W-2:0]), $past(wr_bit_i)});

  // R8
  lh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(hist_q));

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tbp_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int HIST_W    = 4,
  parameter int LHT_IDX_W = 4,
  parameter int CHO_IDX_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  output logic            use_global_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);

  logic [LHT_IDX_W-1:0] lk_lht_idx, up_lht_idx;
  logic [CHO_IDX_W-1:0] lk_cho_idx, up_cho_idx;

  assign lk_lht_idx = lookup_pc_i[PC_LSB +: LHT_IDX_W];
  assign up_lht_idx = upd_pc_i[PC_LSB +: LHT_IDX_W];
  assign lk_cho_idx = lookup_pc_i[PC_LSB +: CHO_IDX_W];
  assign up_cho_idx = upd_pc_i[PC_LSB +: CHO_IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc_i, upd_pc_i};

  // global history, newest outcome in bit 0
  logic [HIST_W-1:0] ghr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken_i};
  end

  logic [HIST_W-1:0] lk_lhist, up_lhist;

  tbp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(HIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i  (lk_lht_idx),
    .rd_hist_o (lk_lhist),
    .upd_idx_i (up_lht_idx),
    .upd_hist_o(up_lhist),
    .wr_en_i   (upd_valid_i),
    .wr_bit_i  (upd_taken_i)
  );

  ctr_t g_lk_ctr, g_up_ctr, l_lk_ctr, l_up_ctr, c_lk_ctr, c_up_ctr;
  logic g_up_pred, l_up_pred, cho_wr, cho_up;

  tbp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WNT)) u_gpht (
    .clk_i, .rst_ni,
    .rd_idx_i (ghr_q),
    .rd_ctr_o (g_lk_ctr),
    .upd_idx_i(ghr_q),
    .upd_ctr_o(g_up_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_up_i  (upd_taken_i)
  );

  tbp_ctr_table #(.IDX_W(HIST_W), .RST_VAL(CTR_WNT)) u_lpht (
    .clk_i, .rst_ni,
    .rd_idx_i (lk_lhist),
    .rd_ctr_o (l_lk_ctr),
    .upd_idx_i(up_lhist),
    .upd_ctr_o(l_up_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_up_i  (upd_taken_i)
  );

  // chooser trains only on disagreement; up = toward global
  assign g_up_pred = g_up_ctr[1];
  assign l_up_pred = l_up_ctr[1];
  assign cho_wr    = upd_valid_i && (g_up_pred != l_up_pred);
  assign cho_up    = (g_up_pred == upd_taken_i);

  tbp_ctr_table #(.IDX_W(CHO_IDX_W), .RST_VAL(CTR_WNT)) u_cho (
    .clk_i, .rst_ni,
    .rd_idx_i (lk_cho_idx),
    .rd_ctr_o (c_lk_ctr),
    .upd_idx_i(up_cho_idx),
    .upd_ctr_o(c_up_ctr),
    .wr_en_i  (cho_wr),
    .wr_up_i  (cho_up)
  );

  assign use_global_o = c_lk_ctr[1];
  assign pred_taken_o = use_global_o ? g_lk_ctr[1] : l_lk_ctr[1];

  logic unused_cho;
  assign unused_cho = ^c_up_ctr;

  // R3
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghr_q[0] == $past(upd_taken_i) &&
                    ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0]));

  // R8
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q));

endmodule

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        pred_taken, use_global;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tournament_predictor i_tournament_predictor (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .lookup_pc_i (lookup_pc),
    .pred_taken_o(pred_taken),
    .use_global_o(use_global),
    .upd_valid_i (upd_valid),
    .upd_pc_i    (upd_pc),
    .upd_taken_i (upd_taken)
  );

  localparam logic [31:0] PC_A = 32'h0000_1010; // index 4
  localparam logic [31:0] PC_B = 32'h0000_2014; // index 5
  localparam logic [31:0] PC_C = 32'h0000_3018; // index 6
  localparam logic [31:0] PC_D = 32'h0000_401c; // index 7

  // reference state built from the requirement text
  logic [3:0] m_ghr;
  logic [3:0] m_lh [16];
  logic [1:0] m_g  [16];
  logic [1:0] m_l  [16];
  logic [1:0] m_c  [16];

  function automatic logic [1:0] sat(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? 2'd3 : v + 2'd1;
    return (v == 2'd0) ? 2'd0 : v - 2'd1;
  endfunction

  task automatic m_reset();
    m_ghr = '0;
    for (int i = 0; i < 16; i++) begin
      m_lh[i] = '0; m_g[i] = 2'd1; m_l[i] = 2'd1; m_c[i] = 2'd1;
    end
  endtask

  function automatic logic m_use_g(input logic [31:0] pc);
    return m_c[pc[5:2]][1];
  endfunction

  function automatic logic m_pred(input logic [31:0] pc);
    return m_c[pc[5:2]][1] ? m_g[m_ghr][1] : m_l[m_lh[pc[5:2]]][1];
  endfunction

  task automatic m_update(input logic [31:0] pc, input logic t);
    logic gp, lp;
    logic [3:0] k;
    k  = pc[5:2];
    gp = m_g[m_ghr][1];
    lp = m_l[m_lh[k]][1];
    m_g[m_ghr]   = sat(m_g[m_ghr], t);
    m_l[m_lh[k]] = sat(m_l[m_lh[k]], t);
    if (gp != lp) m_c[k] = sat(m_c[k], gp == t);
    m_ghr = {m_ghr[2:0], t};
    m_lh[k] = {m_lh[k][2:0], t};
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at the falling edge; outputs then show pre-update state
  task automatic drive(input logic v, input logic [31:0] upc, input logic t,
                       input logic [31:0] lpc);
    @(negedge clk);
    upd_valid = v; upd_pc = upc; upd_taken = t; lookup_pc = lpc;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    upd_valid = 1'b0;
    rst_n = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    drive(1'b0, '0, 1'b0, PC_A);
    check("R1 pred after reset", pred_taken, 1'b0);
    check("R1 chooser after reset", use_global, 1'b0);
    drive(1'b0, '0, 1'b0, PC_D);
    check("R1 pred after reset, other pc", pred_taken, 1'b0);
    check("R1 chooser after reset, other pc", use_global, 1'b0);
  endtask

  // warm-up with one branch; both histories march 0000->1111
  task automatic t_warm();
    do_reset();
    for (int i = 0; i < 4; i++) drive(1'b1, PC_A, 1'b1, PC_A);
    drive(1'b1, PC_A, 1'b1, PC_A);
    check("R7 lookup during update sees old counter", pred_taken, 1'b0);
    drive(1'b0, PC_A, 1'b0, PC_A);
    check("R7 R4 update visible next cycle", pred_taken, 1'b1);
    drive(1'b1, PC_A, 1'b1, PC_A);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, PC_A, 1'b0, PC_A);
      check("R8 idle strobe leaves prediction", pred_taken, 1'b1);
    end
  endtask

  // strong-taken counter at history 1111 needs two not-taken hits to flip
  task automatic t_hyst();
    drive(1'b1, PC_A, 1'b0, PC_A);
    for (int i = 0; i < 4; i++) drive(1'b1, PC_A, 1'b1, PC_A);
    drive(1'b0, PC_A, 1'b0, PC_A);
    check("R2 one miss keeps taken", pred_taken, 1'b1);
    drive(1'b1, PC_A, 1'b0, PC_A);
    for (int i = 0; i < 4; i++) drive(1'b1, PC_A, 1'b1, PC_A);
    drive(1'b0, PC_A, 1'b0, PC_A);
    check("R2 second miss flips", pred_taken, 1'b0);
    check("R5 agreeing components leave chooser", use_global, 1'b0);
  endtask

  // several branches; components disagree and chooser trains
  task automatic t_mixed();
    logic [15:0] lfsr;
    logic        b_t;
    logic [31:0] upc, lpc;
    logic        t;
    logic        saw_global;
    do_reset();
    lfsr = 16'hace1;
    b_t  = 1'b0;
    saw_global = 1'b0;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: begin upc = PC_A; t = 1'b1; end
        2'd1: begin upc = PC_B; b_t = ~b_t; t = b_t; end
        2'd2: begin upc = PC_C; t = lfsr[5]; end
        default: begin upc = PC_D; t = 1'b0; end
      endcase
      case (lfsr[3:2])
        2'd0: lpc = PC_A;
        2'd1: lpc = PC_B;
        2'd2: lpc = PC_C;
        default: lpc = PC_D;
      endcase
      drive(1'b1, upc, t, lpc);
      check("R3 R4 R6 final prediction", pred_taken, m_pred(lpc));
      check("R5 R6 chooser selection", use_global, m_use_g(lpc));
      if (m_use_g(lpc)) saw_global = 1'b1;
      m_update(upc, t);
    end
    drive(1'b0, '0, 1'b0, PC_B);
    check("R6 final prediction after stream", pred_taken, m_pred(PC_B));
    if (!saw_global) $display("note: chooser never selected global in this stream");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run hung (all requirements)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_reset();
    t_reset();
    t_warm();
    t_hyst();
    t_mixed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule